// File: doc/BRIEF.md
# MDIO Management Register Bridge

This block lets a host reach the management registers of an Ethernet PHY through one 32-bit control word. The host writes the word once. The word holds the direction of the access, the 5-bit PHY register number and, for a write, the 16-bit value. The bridge then runs a complete MII management frame on the MDC/MDIO pins to the PHY at bus address 1.

Bit 31 of the same word tells the host when the access has finished. For a write the host sets bit 31, and the bridge clears it at completion. For a read the host clears bit 31, and the bridge sets it once the returned value sits in bits 15:0. The host polls the word until the flag shows completion. A one-cycle `done` pulse gives the same event to logic that prefers an interrupt-style indication.

MDC is produced by dividing the system clock and runs only while a frame is in flight. While a frame is running, the word accepts no new writes.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset, `reg_rdata` at the word's offset reads 0x00000000, and `mdc`, `mdio_oe` and `done` are all low.
- R2: The word answers only at offset `REG_OFFSET` (default 0x60). A write to any other offset starts nothing and leaves the word unchanged. A read at any other offset returns 0.
- R3: A write with bit 31 = 1 starts a PHY write. Bit 31 reads 1 while the frame runs and reads 0 after completion. Bits 20:16 (register number) and 15:0 (data) keep the written values.
- R4: A write with bit 31 = 0 starts a PHY read. Bit 31 reads 0 while the frame runs. At completion bit 31 reads 1, bits 15:0 hold the 16 bits sampled from MDIO, and bits 20:16 keep the register number. Bits 30:21 always read 0.
- R5: Each frame has 64 MDC cycles, and the first bit is listed first here. It begins with 32 ones. Then come start code 01 and opcode 01 (write) or 10 (read). Then come PHY address 00001 and the register number, MSB first. Then comes a turnaround, driven as 10 on a write. Last come 16 data bits, MSB first.
- R6: MDC is low when idle. During a frame, each MDC half-period lasts `MDC_HALF` system clock cycles.
- R7: The MDIO output changes only while MDC is low (launched at the falling edge). MDIO input is sampled at the rising edge.
- R8: On a read, `mdio_oe` is low for the two turnaround bits and all 16 data bits, and high for the first 46 bits. On a write, `mdio_oe` is high for all 64 bits.
- R9: A write to the word while a frame is running is ignored. The running frame and its result are unaffected.
- R10: `done` is high for exactly one cycle at each completion, in the same cycle the flag takes its completion value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (word at `REG_OFFSET`, else 0) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench models a PHY on the MDC edges. At every rising edge it records what the bridge drives and whether the bridge drives at all, and it returns read data launched at falling edges. It checks that the captured frame and enable pattern match the expected frame bit for bit.

Corner cases covered:
- **Flag sense.** Reads and writes are mixed. A bridge that used the same flag sense for both would leave a read looking unfinished.
- **Writes while busy.** A second write is aimed into a running frame. A bridge that accepted it would corrupt the register field or restart the frame.
- **Other offsets.** Writes go to a different offset. A bridge with a loose offset decode would start a frame.
- **All-ones and all-zeros data.** These patterns expose dropped or shifted bits.
- **Driver release.** The enable pattern is checked bit by bit. A bridge releasing MDIO one bit late would fight the PHY in turnaround.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int FRAME_LEN   = 64;
  localparam int PRE_LEN     = 32;
  localparam int RD_FIRST    = 48;
  localparam int RELEASE_BIT = 46;
  localparam int CNT_W       = $clog2(FRAME_LEN + 1);
  localparam logic [4:0] PHY_ADDR = 5'd1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  function automatic logic [FRAME_LEN-1:0] frame_bits(input logic wr, input logic [4:0] ra,
                                                       input logic [15:0] d);
    mdio_op_e op;
    op = wr ? OP_WRITE : OP_READ;
    return {{PRE_LEN{1'b1}}, 2'b01, op, PHY_ADDR, ra, (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [FRAME_LEN-1:0] drive_mask(input logic wr);
    return wr ? {FRAME_LEN{1'b1}}
              : {{RELEASE_BIT{1'b1}}, {(FRAME_LEN-RELEASE_BIT){1'b0}}};
  endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == CW'(HALF - 1));
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_wr,
  input  logic [4:0]  reg_num,
  input  logic [15:0] wr_data,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        finish,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_LEN-1:0] out_sr;
  logic [FRAME_LEN-1:0] oe_sr;
  logic [CNT_W-1:0]     rise_cnt;
  logic                 wr_q;
  logic [15:0]          in_sr;

  assign finish  = busy && fall_tick && (rise_cnt == CNT_W'(FRAME_LEN));
  assign rd_data = in_sr;
  assign mdio_o  = out_sr[FRAME_LEN-1];
  assign mdio_oe = busy && oe_sr[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      out_sr   <= '1;
      oe_sr    <= '0;
      rise_cnt <= '0;
      wr_q     <= 1'b0;
      in_sr    <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      wr_q     <= is_wr;
      rise_cnt <= '0;
      out_sr   <= frame_bits(is_wr, reg_num, wr_data);
      oe_sr    <= drive_mask(is_wr);
    end else if (busy) begin
      if (rise_tick) begin
        rise_cnt <= rise_cnt + CNT_W'(1);
        if (!wr_q && rise_cnt >= CNT_W'(RD_FIRST))
          in_sr <= {in_sr[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (rise_cnt == CNT_W'(FRAME_LEN)) begin
          busy <= 1'b0;
        end else begin
          out_sr <= {out_sr[FRAME_LEN-2:0], 1'b0};
          oe_sr  <= {oe_sr[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  // R8: once the turnaround bit is launched on a read, the pin stays released
  assert_read_release_R8: assert property (@(posedge clk) disable iff (rst)
    busy && !wr_q && rise_cnt >= CNT_W'(RELEASE_BIT + 1) |-> !mdio_oe);
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h60,
  parameter int              MDC_HALF   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              done
);
  logic        hit, start, busy, finish, rise_tick, fall_tick;
  logic [15:0] rd_data;
  logic [31:0] word_q;

  assign hit       = (reg_addr == REG_OFFSET);
  assign start     = reg_wr && hit && !busy;
  assign reg_rdata = hit ? word_q : 32'h0;

  mdc_gen #(.HALF(MDC_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .is_wr(reg_wdata[31]),
    .reg_num(reg_wdata[20:16]), .wr_data(reg_wdata[15:0]),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .finish(finish), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        word_q <= {reg_wdata[31], 10'h0, reg_wdata[20:0]};
      end else if (finish) begin
        if (word_q[31]) begin
          word_q[31] <= 1'b0;
        end else begin
          word_q[31]   <= 1'b1;
          word_q[15:0] <= rd_data;
        end
      end
    end
  end

  assert_mdio_launch_low_R7: assert property (@(posedge clk) disable iff (rst)
    $changed(mdio_o) |-> !mdc);
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(word_q[20:16]));
  assert_write_flag_clears_R3: assert property (@(posedge clk) disable iff (rst)
    finish && word_q[31] |=> !word_q[31] && done);
  assert_read_flag_sets_R4: assert property (@(posedge clk) disable iff (rst)
    finish && !word_q[31] |=> word_q[31] && done);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_drive_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);
endmodule

// File: tb/phy_mgmt_bridge_test.sv
module phy_mgmt_bridge_test;
  localparam int HALF = 2;
  localparam logic [7:0] OFS = 8'h60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = OFS;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, done;
  logic        mdio_i = 1'b1;

  int          n_chk = 0, n_bad = 0;
  int          rise_tot = 0, base = 0;
  logic [63:0] cap_o = '0, cap_oe = '0;
  logic [15:0] phy_val = '0;
  time         t_r0 = 0, t_r1 = 0;

  phy_mgmt_bridge #(.ADDR_W(8), .REG_OFFSET(OFS), .MDC_HALF(HALF)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .done(done)
  );

  always #2 clk = ~clk;

  // PHY model: record each bit at rising MDC, answer reads at falling MDC
  always @(posedge mdc) begin
    int idx;
    idx = rise_tot - base;
    if (idx >= 0 && idx < 64) begin
      cap_o[63-idx]  = mdio_o;
      cap_oe[63-idx] = mdio_oe;
    end
    if (idx == 0) t_r0 = $time;
    if (idx == 1) t_r1 = $time;
    rise_tot = rise_tot + 1;
  end

  always @(negedge mdc) begin
    int idx;
    idx = rise_tot - base;
    if (idx >= 48 && idx < 64) mdio_i = phy_val[63-idx];
    else if (idx == 47)        mdio_i = 1'b0;
    else                       mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 5'd1, ra, (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [63:0] exp_mask(input bit wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, {18{1'b0}}};
  endfunction

  function automatic logic [31:0] exp_word(input bit wr, input logic [4:0] ra,
                                           input logic [15:0] d, input logic [15:0] phy);
    return wr ? {11'h0, ra, d} : {1'b1, 10'h0, ra, phy};
  endfunction

  task automatic access(input bit wr, input logic [4:0] ra, input logic [15:0] d,
                        input logic [15:0] phy, input bit poke);
    int n;
    logic [63:0] m;
    phy_val = phy;
    base = rise_tot;
    @(negedge clk);
    reg_addr  = OFS;
    reg_wdata = {wr, 10'h2A5, ra, d};
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(wr ? "R3 flag during write" : "R4 flag during read", {63'h0, reg_rdata[31]}, {63'h0, wr});
    if (poke) begin
      repeat (10) @(negedge clk);
      reg_wdata = {~wr, 10'h0, ~ra, ~d};
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R9 busy write ignored", {32'h0, reg_rdata}, {32'h0, wr, 10'h0, ra, d});
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", {63'h0, done}, 64'h1);
    chk(wr ? "R3 completion word" : "R4 completion word", {32'h0, reg_rdata},
        {32'h0, exp_word(wr, ra, d, phy)});
    @(negedge clk);
    chk("R10 done one cycle", {63'h0, done}, 64'h0);
    chk("R6 mdc idle low", {63'h0, mdc}, 64'h0);
    chk("R5 frame length", 64'(rise_tot - base), 64'd64);
    m = exp_mask(wr);
    chk("R8 drive pattern", cap_oe, m);
    chk("R5 frame bits", cap_o & m, exp_frame(wr, ra, d) & m);
    chk("R6 mdc period", 64'(t_r1 - t_r0), 64'(2 * HALF * 4));
  endtask

  initial begin
    int guard;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset word", {32'h0, reg_rdata}, 64'h0);
    chk("R1 reset pins", {61'h0, mdc, mdio_oe, done}, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    access(1'b1, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
    access(1'b0, 5'h00, 16'h1234, 16'h0000, 1'b0);
    access(1'b0, 5'h0B, 16'h0, 16'hA5C3, 1'b1);   // R7 sampling checked via returned data
    access(1'b1, 5'h04, 16'h0000, 16'h0, 1'b1);

    // R2: writes to another offset start nothing
    @(negedge clk);
    reg_addr = 8'h64;
    reg_wdata = 32'h8003_BEEF;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R2 other offset reads zero", {32'h0, reg_rdata}, 64'h0);
    guard = 0;
    repeat (40) begin
      @(negedge clk);
      if (mdc) guard++;
    end
    chk("R2 no frame from other offset", 64'(guard), 64'h0);
    reg_addr = OFS;
    @(negedge clk);
    chk("R2 word unchanged", {32'h0, reg_rdata}, {32'h0, 11'h0, 5'h04, 16'h0000});

    for (int i = 0; i < 10; i++) begin
      access(1'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule